// File: doc/BRIEF.md
# Push-Button Gesture Controller for a Voice Recorder

This block sits between four debounced, active-low push buttons (record, play, erase, forward) and the sequencer of a voice record/playback engine. It turns presses, releases and long holds into one-cycle command strobes that carry an opcode. After a strobe it waits for the sequencer's completion pulse before it accepts new buttons. The same buttons take on different meanings depending on four things: a short pulse or a long hold, a second button pressed during a hold, whether playback is running, and whether the block is in sound-effect editing mode.

A long forward hold followed by a record press toggles sound-effect editing mode. In that mode, short forward presses cycle through the sound-effect slots. The block reports the selected slot and a start row for the sequencer. Each sound-effect slot owns a fixed group of rows at the bottom of the array, and voice data starts above them. Counted LED blink sequences confirm mode changes and slot selection, and all buttons are ignored while a sequence runs. An active-low-busy ready output and the LED show what the block is doing. The hold threshold and the blink half-period are system-clock cycle counts set by parameters.

Top module: `gesture_ctrl`

## Requirements
- R1: From idle, a record press (rec_n high to low) emits REC_START (opcode 1). While rec_n stays low nothing more is emitted. The cycle after rec_n is seen high, REC_STOP (2) is emitted and the block waits for seq_done.
- R2: From idle, a play press emits PLAY (3). A second play press during playback emits STOP (4). When seq_done arrives during playback with play_n still low, PLAY is emitted again (looping). When seq_done arrives with play_n high, the block returns to idle.
- R3: An erase press opens a hold window. If erase is released before HOLD_TICKS cycles, ERASE (6) is emitted only when at_edge_msg is high; otherwise nothing is emitted. If erase is still low HOLD_TICKS cycles after the press edge, GLOBAL_ERASE (7) is emitted.
- R4: Outside editing mode, a forward press released before HOLD_TICKS cycles emits FWD (5) on release. A forward press during playback emits FWD and playback continues.
- R5: Holding forward for HOLD_TICKS cycles and then pressing record toggles editing mode. Entering selects slot 0 and blinks the LED once. Leaving blinks it twice. No command is emitted for either.
- R6: In editing mode, a short forward press advances the slot by one, wrapping from the last slot to slot 0, and blinks the LED (slot+1) times. No command is emitted.
- R7: start_row equals slot*SE_ROWS in editing mode and VOICE_BASE otherwise.
- R8: The LED is steadily on while recording. During playback and while waiting for seq_done it follows a free-running square wave that toggles every BLINK_TICKS cycles from reset. During a counted sequence each blink is BLINK_TICKS cycles on and then BLINK_TICKS off. It is off otherwise.
- R9: While a counted blink sequence runs, every button press is ignored.
- R10: rdy is low while recording, playing or waiting for seq_done, and high otherwise.
- R11: cmd_vld is a one-cycle strobe with a nonzero cmd_op. After reset cmd_vld is 0, rdy is 1, led is 0 and editing mode is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rec_n | input | 1 | Record button, active low, debounced |
| play_n | input | 1 | Play button, active low, debounced |
| erase_n | input | 1 | Erase button, active low, debounced |
| fwd_n | input | 1 | Forward button, active low, debounced |
| seq_done | input | 1 | Sequencer finished the current operation |
| at_edge_msg | input | 1 | Play pointer is at the first or last message |
| cmd_vld | output | 1 | One-cycle command strobe |
| cmd_op | output | 3 | Command opcode (see R1-style encodings in requirements) |
| rdy | output | 1 | High when idle, low while an operation runs |
| led | output | 1 | Indicator LED drive |
| se_mode | output | 1 | Sound-effect editing mode active |
| se_slot | output | $clog2(SE_SLOTS) | Selected sound-effect slot |
| start_row | output | ROW_W | Start row for the next record or play |

## Verification
Every strobe is registered. It appears one cycle after the rising edge that samples the deciding button level, so a press driven at a falling edge is visible at the next falling edge. A global erase strobe appears HOLD_TICKS cycles after the edge that opened the hold window. A counted blink sequence of n blinks holds the block for 2·n·BLINK_TICKS cycles. The bench advances its reference model on each rising edge from the same sampled inputs and compares all outputs at every falling edge, so each of these latencies is checked in the exact cycle it is due.

// File: rtl/gesture_pkg.sv
package gesture_pkg;

    typedef enum logic [2:0] {
        OP_NONE      = 3'd0,
        OP_REC_START = 3'd1,
        OP_REC_STOP  = 3'd2,
        OP_PLAY      = 3'd3,
        OP_STOP      = 3'd4,
        OP_FWD       = 3'd5,
        OP_ERASE     = 3'd6,
        OP_GERASE    = 3'd7
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REC,
        ST_PLAY,
        ST_WAIT,
        ST_FHOLD,
        ST_EHOLD,
        ST_BLINK
    } st_e;

    localparam int NBTN    = 4;
    localparam int BTN_REC = 0;
    localparam int BTN_PLY = 1;
    localparam int BTN_ERS = 2;
    localparam int BTN_FWD = 3;

endpackage

// File: rtl/gest_edges.sv
module gest_edges #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] btn_n,
    output logic [N-1:0] fall
);
    logic [N-1:0] prev_d, prev_q;

    for (genvar i = 0; i < N; i++) begin : g_btn
        always_comb begin
            prev_d[i] = btn_n[i];
            fall[i]   = prev_q[i] & ~btn_n[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/gest_phase.sv
module gest_phase #(
    parameter int BLINK_TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic phase
);
    localparam int BW = (BLINK_TICKS > 1) ? $clog2(BLINK_TICKS) : 1;

    typedef struct packed {
        logic [BW-1:0] tick;
        logic          ph;
    } ph_t;

    ph_t ph_d, ph_q;

    always_comb begin
        ph_d = ph_q;
        if (ph_q.tick == BW'(BLINK_TICKS - 1)) begin
            ph_d.tick = '0;
            ph_d.ph   = ~ph_q.ph;
        end else begin
            ph_d.tick = ph_q.tick + BW'(1);
        end
        phase = ph_q.ph;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= '0;
        else        ph_q <= ph_d;
    end
endmodule

// File: rtl/gest_row_map.sv
module gest_row_map #(
    parameter int SE_SLOTS   = 4,
    parameter int SE_ROWS    = 4,
    parameter int VOICE_BASE = 16,
    parameter int ROW_W      = 11
) (
    input  logic                        se,
    input  logic [$clog2(SE_SLOTS)-1:0] slot,
    output logic [ROW_W-1:0]            row
);
    always_comb begin
        if (se) row = ROW_W'(slot) * ROW_W'(SE_ROWS);
        else    row = ROW_W'(VOICE_BASE);
    end
endmodule

// File: rtl/gesture_ctrl.sv
module gesture_ctrl
    import gesture_pkg::*;
#(
    parameter int HOLD_TICKS  = 150_000_000,
    parameter int BLINK_TICKS = 12_500_000,
    parameter int SE_SLOTS    = 4,
    parameter int SE_ROWS     = 4,
    parameter int VOICE_BASE  = 16,
    parameter int ROW_W       = 11
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rec_n,
    input  logic                        play_n,
    input  logic                        erase_n,
    input  logic                        fwd_n,
    input  logic                        seq_done,
    input  logic                        at_edge_msg,
    output logic                        cmd_vld,
    output logic [2:0]                  cmd_op,
    output logic                        rdy,
    output logic                        led,
    output logic                        se_mode,
    output logic [$clog2(SE_SLOTS)-1:0] se_slot,
    output logic [ROW_W-1:0]            start_row
);
    localparam int HW     = $clog2(HOLD_TICKS + 1);
    localparam int BW     = (BLINK_TICKS > 1) ? $clog2(BLINK_TICKS) : 1;
    localparam int SW     = $clog2(SE_SLOTS);
    localparam int HALF_W = $clog2(2 * SE_SLOTS + 1);

    typedef struct packed {
        st_e             st;
        logic [HW-1:0]   hold;
        logic            se;
        logic [SW-1:0]   slot;
        logic [BW-1:0]   sub;
        logic [HALF_W-1:0] half;
        logic            vld;
        op_e             op;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NBTN-1:0] fall;
    logic            phase;
    logic            blink_act;
    logic            armed;
    logic [SW-1:0]   nxt_slot;

    gest_edges #(.N(NBTN)) u_edges (
        .clk   (clk),
        .rst_n (rst_n),
        .btn_n ({fwd_n, erase_n, play_n, rec_n}),
        .fall  (fall)
    );

    gest_phase #(.BLINK_TICKS(BLINK_TICKS)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase)
    );

    gest_row_map #(
        .SE_SLOTS   (SE_SLOTS),
        .SE_ROWS    (SE_ROWS),
        .VOICE_BASE (VOICE_BASE),
        .ROW_W      (ROW_W)
    ) u_rows (
        .se   (ctl_q.se),
        .slot (ctl_q.slot),
        .row  (start_row)
    );

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.vld = 1'b0;
        ctl_d.op  = OP_NONE;
        armed     = (ctl_q.hold == HW'(HOLD_TICKS));
        nxt_slot  = (ctl_q.slot == SW'(SE_SLOTS - 1)) ? '0 : ctl_q.slot + SW'(1);

        unique case (ctl_q.st)
            ST_IDLE: begin
                if (fall[BTN_REC]) begin
                    ctl_d.vld = 1'b1; ctl_d.op = OP_REC_START; ctl_d.st = ST_REC;
                end else if (fall[BTN_PLY]) begin
                    ctl_d.vld = 1'b1; ctl_d.op = OP_PLAY; ctl_d.st = ST_PLAY;
                end else if (fall[BTN_ERS]) begin
                    ctl_d.st = ST_EHOLD; ctl_d.hold = '0;
                end else if (fall[BTN_FWD]) begin
                    ctl_d.st = ST_FHOLD; ctl_d.hold = '0;
                end
            end
            ST_REC: begin
                if (rec_n) begin
                    ctl_d.vld = 1'b1; ctl_d.op = OP_REC_STOP; ctl_d.st = ST_WAIT;
                end
            end
            ST_PLAY: begin
                if (fall[BTN_PLY]) begin
                    ctl_d.vld = 1'b1; ctl_d.op = OP_STOP; ctl_d.st = ST_WAIT;
                end else if (fall[BTN_FWD]) begin
                    ctl_d.vld = 1'b1; ctl_d.op = OP_FWD;
                end else if (seq_done) begin
                    if (!play_n) begin
                        ctl_d.vld = 1'b1; ctl_d.op = OP_PLAY;
                    end else begin
                        ctl_d.st = ST_IDLE;
                    end
                end
            end
            ST_WAIT: begin
                if (seq_done) ctl_d.st = ST_IDLE;
            end
            ST_EHOLD: begin
                if (erase_n) begin
                    if (at_edge_msg) begin
                        ctl_d.vld = 1'b1; ctl_d.op = OP_ERASE; ctl_d.st = ST_WAIT;
                    end else begin
                        ctl_d.st = ST_IDLE;
                    end
                end else if (ctl_q.hold == HW'(HOLD_TICKS - 1)) begin
                    ctl_d.vld = 1'b1; ctl_d.op = OP_GERASE; ctl_d.st = ST_WAIT;
                end else begin
                    ctl_d.hold = ctl_q.hold + HW'(1);
                end
            end
            ST_FHOLD: begin
                if (fwd_n) begin
                    if (armed) begin
                        ctl_d.st = ST_IDLE;
                    end else if (ctl_q.se) begin
                        ctl_d.slot = nxt_slot;
                        ctl_d.st   = ST_BLINK;
                        ctl_d.sub  = '0;
                        ctl_d.half = HALF_W'({({1'b0, nxt_slot} + (SW+1)'(1)), 1'b0});
                    end else begin
                        ctl_d.vld = 1'b1; ctl_d.op = OP_FWD; ctl_d.st = ST_WAIT;
                    end
                end else if (armed && fall[BTN_REC]) begin
                    ctl_d.st  = ST_BLINK;
                    ctl_d.sub = '0;
                    if (ctl_q.se) begin
                        ctl_d.se   = 1'b0;
                        ctl_d.half = HALF_W'(4);
                    end else begin
                        ctl_d.se   = 1'b1;
                        ctl_d.slot = '0;
                        ctl_d.half = HALF_W'(2);
                    end
                end else if (!armed) begin
                    ctl_d.hold = ctl_q.hold + HW'(1);
                end
            end
            ST_BLINK: begin
                if (ctl_q.sub == BW'(BLINK_TICKS - 1)) begin
                    ctl_d.sub  = '0;
                    ctl_d.half = ctl_q.half - HALF_W'(1);
                    if (ctl_q.half == HALF_W'(1)) ctl_d.st = ST_IDLE;
                end else begin
                    ctl_d.sub = ctl_q.sub + BW'(1);
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.st <= ST_IDLE;
            ctl_q.op <= OP_NONE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        blink_act = (ctl_q.st == ST_BLINK);
        cmd_vld   = ctl_q.vld;
        cmd_op    = ctl_q.op;
        se_mode   = ctl_q.se;
        se_slot   = ctl_q.slot;
        rdy       = !(ctl_q.st inside {ST_REC, ST_PLAY, ST_WAIT});
        unique case (ctl_q.st)
            ST_REC:           led = 1'b1;
            ST_PLAY, ST_WAIT: led = phase;
            ST_BLINK:         led = ~ctl_q.half[0];
            default:          led = 1'b0;
        endcase
    end
endmodule

// File: rtl/gesture_ctrl_chk.sv
module gesture_ctrl_chk #(
    parameter int SE_SLOTS   = 4,
    parameter int SE_ROWS    = 4,
    parameter int VOICE_BASE = 16,
    parameter int ROW_W      = 11
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        erase_n,
    input logic                        cmd_vld,
    input logic [2:0]                  cmd_op,
    input logic                        rdy,
    input logic                        se_mode,
    input logic [$clog2(SE_SLOTS)-1:0] se_slot,
    input logic [ROW_W-1:0]            start_row,
    input logic                        in_blink
);
    AST_REC_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && cmd_op == 3'd1) |-> (!rdy && $past(rdy))); // R1

    AST_GERASE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && cmd_op == 3'd7) |-> $past(!erase_n)); // R3

    AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (se_mode && $past(se_mode) && se_slot != $past(se_slot)) |->
        (int'(se_slot) == ((int'($past(se_slot)) == SE_SLOTS - 1) ? 0 : int'($past(se_slot)) + 1))); // R6

    AST_SE_ROW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        se_mode |-> (int'(start_row) < SE_SLOTS * SE_ROWS)); // R7

    AST_VOICE_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        !se_mode |-> (int'(start_row) == VOICE_BASE)); // R7

    AST_BLINK_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
        in_blink |-> !cmd_vld); // R9

    AST_STROBE_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_vld |-> (cmd_op != 3'd0)); // R11
endmodule

bind gesture_ctrl gesture_ctrl_chk #(
    .SE_SLOTS   (SE_SLOTS),
    .SE_ROWS    (SE_ROWS),
    .VOICE_BASE (VOICE_BASE),
    .ROW_W      (ROW_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .erase_n   (erase_n),
    .cmd_vld   (cmd_vld),
    .cmd_op    (cmd_op),
    .rdy       (rdy),
    .se_mode   (se_mode),
    .se_slot   (se_slot),
    .start_row (start_row),
    .in_blink  (blink_act)
);

// File: tb/gesture_ctrl_tb_top.sv
module gesture_ctrl_tb_top;
    localparam int HT = 20;
    localparam int BT = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rec_n = 1'b1, play_n = 1'b1, erase_n = 1'b1, fwd_n = 1'b1;
    logic seq_done = 1'b0, at_edge_msg = 1'b0;
    logic       cmd_vld, rdy, led, se_mode;
    logic [2:0] cmd_op;
    logic [1:0] se_slot;
    logic [10:0] start_row;

    int checks = 0;
    int fails  = 0;
    string cur_req = "R11";
    bit done_flag = 0;

    always #10 clk = ~clk;

    gesture_ctrl #(.HOLD_TICKS(HT), .BLINK_TICKS(BT)) dut_i (
        .clk(clk), .rst_n(rst_n), .rec_n(rec_n), .play_n(play_n),
        .erase_n(erase_n), .fwd_n(fwd_n), .seq_done(seq_done),
        .at_edge_msg(at_edge_msg), .cmd_vld(cmd_vld), .cmd_op(cmd_op),
        .rdy(rdy), .led(led), .se_mode(se_mode), .se_slot(se_slot),
        .start_row(start_row)
    );

    // Behavioural reference model. States: 0 idle, 1 rec, 2 play, 3 wait,
    // 4 forward hold, 5 erase hold, 6 counted blink.
    int m_st = 0, m_hold = 0, m_se = 0, m_slot = 0;
    int m_tick = 0, m_phase = 0, m_sub = 0, m_half = 0;
    int m_vld = 0, m_op = 0;
    int p_rec = 1, p_ply = 1, p_ers = 1, p_fwd = 1;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_hold = 0; m_se = 0; m_slot = 0; m_tick = 0; m_phase = 0;
            m_sub = 0; m_half = 0; m_vld = 0; m_op = 0;
            p_rec = 1; p_ply = 1; p_ers = 1; p_fwd = 1;
        end else begin
            bit f_rec, f_ply, f_ers, f_fwd;
            f_rec = (p_rec == 1) && !rec_n;
            f_ply = (p_ply == 1) && !play_n;
            f_ers = (p_ers == 1) && !erase_n;
            f_fwd = (p_fwd == 1) && !fwd_n;
            m_vld = 0; m_op = 0;
            if (m_tick == BT - 1) begin m_tick = 0; m_phase = 1 - m_phase; end
            else m_tick++;
            case (m_st)
                0: if (f_rec) begin m_vld = 1; m_op = 1; m_st = 1; end
                   else if (f_ply) begin m_vld = 1; m_op = 3; m_st = 2; end
                   else if (f_ers) begin m_st = 5; m_hold = 0; end
                   else if (f_fwd) begin m_st = 4; m_hold = 0; end
                1: if (rec_n) begin m_vld = 1; m_op = 2; m_st = 3; end
                2: if (f_ply) begin m_vld = 1; m_op = 4; m_st = 3; end
                   else if (f_fwd) begin m_vld = 1; m_op = 5; end
                   else if (seq_done) begin
                       if (!play_n) begin m_vld = 1; m_op = 3; end
                       else m_st = 0;
                   end
                3: if (seq_done) m_st = 0;
                5: if (erase_n) begin
                       if (at_edge_msg) begin m_vld = 1; m_op = 6; m_st = 3; end
                       else m_st = 0;
                   end else if (m_hold == HT - 1) begin m_vld = 1; m_op = 7; m_st = 3; end
                   else m_hold++;
                4: if (fwd_n) begin
                       if (m_hold == HT) m_st = 0;
                       else if (m_se) begin
                           m_slot = (m_slot + 1) % 4;
                           m_st = 6; m_sub = 0; m_half = 2 * (m_slot + 1);
                       end else begin m_vld = 1; m_op = 5; m_st = 3; end
                   end else if (m_hold == HT && f_rec) begin
                       m_st = 6; m_sub = 0;
                       if (m_se) begin m_se = 0; m_half = 4; end
                       else begin m_se = 1; m_slot = 0; m_half = 2; end
                   end else if (m_hold != HT) m_hold++;
                6: if (m_sub == BT - 1) begin
                       m_sub = 0; m_half--;
                       if (m_half == 0) m_st = 0;
                   end else m_sub++;
                default: m_st = 0;
            endcase
            p_rec = rec_n; p_ply = play_n; p_ers = erase_n; p_fwd = fwd_n;
        end
    end

    task automatic cmp(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!done_flag) begin
            int e_led, e_rdy, e_row;
            e_rdy = (m_st == 1 || m_st == 2 || m_st == 3) ? 0 : 1;
            case (m_st)
                1: e_led = 1;
                2, 3: e_led = m_phase;
                6: e_led = ((m_half % 2) == 0) ? 1 : 0;
                default: e_led = 0;
            endcase
            e_row = m_se ? m_slot * 4 : 16;
            cmp("cmd_vld R11", 32'(cmd_vld), 32'(m_vld));
            cmp("cmd_op R11", 32'(cmd_op), m_vld ? 32'(m_op) : 32'(cmd_op));
            cmp("rdy R10", 32'(rdy), 32'(e_rdy));
            cmp("led R8", 32'(led), 32'(e_led));
            cmp("se_mode R5", 32'(se_mode), 32'(m_se));
            cmp("se_slot R6", 32'(se_slot), 32'(m_slot));
            cmp("start_row R7", 32'(start_row), 32'(e_row));
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic done_pulse();
        @(negedge clk) seq_done = 1'b1;
        @(negedge clk) seq_done = 1'b0;
    endtask

    task automatic finish_run();
        done_flag = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        cur_req = "R11";
        cyc(3);
        @(negedge clk) rst_n = 1'b1;
        cyc(3);

        cur_req = "R1";
        @(negedge clk) rec_n = 1'b0;
        cyc(10);
        @(negedge clk) rec_n = 1'b1;
        cyc(3); done_pulse(); cyc(3);

        cur_req = "R2";
        @(negedge clk) play_n = 1'b0; cyc(2);
        @(negedge clk) play_n = 1'b1; cyc(7);
        @(negedge clk) play_n = 1'b0; cyc(2);
        @(negedge clk) play_n = 1'b1; cyc(2);
        done_pulse(); cyc(2);
        @(negedge clk) play_n = 1'b0; cyc(1);
        @(negedge clk) play_n = 1'b1; cyc(4);
        done_pulse(); cyc(3);
        @(negedge clk) play_n = 1'b0; cyc(4);
        done_pulse(); cyc(4); done_pulse(); cyc(2);
        @(negedge clk) play_n = 1'b1; cyc(2);
        done_pulse(); cyc(3);

        cur_req = "R4";
        @(negedge clk) fwd_n = 1'b0; cyc(3);
        @(negedge clk) fwd_n = 1'b1; cyc(3);
        done_pulse(); cyc(2);
        @(negedge clk) play_n = 1'b0; cyc(1);
        @(negedge clk) play_n = 1'b1; cyc(3);
        @(negedge clk) fwd_n = 1'b0; cyc(1);
        @(negedge clk) fwd_n = 1'b1; cyc(3);
        done_pulse(); cyc(3);
        @(negedge clk) fwd_n = 1'b0; cyc(HT + 4);
        @(negedge clk) fwd_n = 1'b1; cyc(3);

        cur_req = "R3";
        at_edge_msg = 1'b0;
        @(negedge clk) erase_n = 1'b0; cyc(4);
        @(negedge clk) erase_n = 1'b1; cyc(3);
        at_edge_msg = 1'b1;
        @(negedge clk) erase_n = 1'b0; cyc(4);
        @(negedge clk) erase_n = 1'b1; cyc(3);
        done_pulse(); cyc(2);
        @(negedge clk) erase_n = 1'b0; cyc(HT + 5);
        @(negedge clk) erase_n = 1'b1; cyc(2);
        done_pulse(); cyc(3);

        cur_req = "R5";
        @(negedge clk) fwd_n = 1'b0; cyc(HT + 3);
        @(negedge clk) rec_n = 1'b0; cyc(2);
        @(negedge clk) rec_n = 1'b1;
        @(negedge clk) fwd_n = 1'b1; cyc(10);

        cur_req = "R6";
        for (int k = 0; k < 5; k++) begin
            @(negedge clk) fwd_n = 1'b0; cyc(2);
            @(negedge clk) fwd_n = 1'b1; cyc(2 * BT * 4 + 4);
        end

        cur_req = "R9";
        @(negedge clk) fwd_n = 1'b0; cyc(2);
        @(negedge clk) fwd_n = 1'b1; cyc(2);
        @(negedge clk) play_n = 1'b0; cyc(2);
        @(negedge clk) play_n = 1'b1; cyc(1);
        @(negedge clk) rec_n = 1'b0; cyc(1);
        @(negedge clk) rec_n = 1'b1; cyc(2 * BT * 4 + 2);

        cur_req = "R7";
        @(negedge clk) rec_n = 1'b0; cyc(3);
        @(negedge clk) rec_n = 1'b1; cyc(2);
        done_pulse(); cyc(3);

        cur_req = "R5";
        @(negedge clk) fwd_n = 1'b0; cyc(HT + 2);
        @(negedge clk) rec_n = 1'b0; cyc(1);
        @(negedge clk) rec_n = 1'b1;
        @(negedge clk) fwd_n = 1'b1; cyc(2 * BT * 2 + 4);

        cur_req = "R7";
        @(negedge clk) play_n = 1'b0; cyc(1);
        @(negedge clk) play_n = 1'b1; cyc(2);
        done_pulse(); cyc(4);

        finish_run();
    end
endmodule